// File: doc/BRIEF.md
# General Register-and-ALU Process Unit

This block is the datapath half of a small programmable processor. It holds eight 16-bit general registers and an arithmetic-logic unit. An external sequencer drives a flat control word each cycle. The word picks two source registers and a destination register, and it can replace the second operand with an immediate. It also chooses one of fifteen ALU functions and says whether the result is stored. The unit returns a zero-condition bit computed from the ALU result, and the sequencer uses that bit for branching.

Words also move between the registers and a small port address space. An input action stores the word presented on `in_data` into the destination register and raises a read strobe for the addressed port. An output action presents a source register on the output bus with a one-cycle write strobe. These ports are plain strobes with no valid/ready pairing. The sequencer that drives the control word decides when each port action happens, so there is no back-pressure path. An input action is expected to find its word already waiting on `in_data`.

Top module: `pu_datapath`

## Requirements
- R1: After reset every register holds 0 and `out_wr` is low.
- R2: Both read buses return register contents combinationally and independently, even when they select the same register. A write lands on the rising clock edge and can be read in the following cycle.
- R3: `alu_fn` codes 0, 1 and 2 give bitwise AND, OR and XOR of A and B. Code 3 gives the bitwise inverse of A.
- R4: Code 4 gives A+B and code 5 gives A-B, both taken modulo 2^16.
- R5: Codes 6 and 7 shift A by the signed 5-bit value in B[4:0], covering -16 to +15. A positive count shifts left and fills with zero. A negative count shifts right; code 6 fills from the sign bit and code 7 fills with zero.
- R6: Codes 8, 9 and 10 give signed A<B, signed A<=B and A==B. The result is 1 when the relation holds and 0 otherwise.
- R7: Codes 11 and 12 give unsigned A<B and unsigned A<=B, with the same 0/1 result.
- R8: Code 13 passes B unchanged. Code 14 gives {B[7:0], A[7:0]}: it replaces the upper byte and keeps the lower byte of A. Code 15 gives 0.
- R9: When `use_imm` is 1, B is `imm`. Otherwise B is the register selected by `sel_b`.
- R10: `zero_flag` is 1 exactly when the current ALU result is 0. It follows the control word in the same cycle.
- R11: When `in_en` is 1 and `out_en` is 0, `in_rd` is 1 and a write with `wr_en` stores `in_data` in place of the ALU result.
- R12: When `out_en` is 1, the next cycle shows `out_wr`=1 for one cycle, carrying the A register value and `io_addr` from the issuing cycle. No register is written in that cycle, even if `wr_en` is 1.
- R13: With `wr_en` at 0, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_a | input | 3 | Register on read bus A |
| sel_b | input | 3 | Register on read bus B |
| sel_d | input | 3 | Destination register |
| use_imm | input | 1 | Take B from `imm` |
| imm | input | 16 | Immediate operand |
| alu_fn | input | 4 | ALU function code |
| wr_en | input | 1 | Store the result in `sel_d` |
| in_en | input | 1 | Input action: store `in_data` |
| out_en | input | 1 | Output action: send A out |
| io_addr | input | 8 | Port address for input or output |
| in_data | input | 16 | Word from the addressed input port |
| zero_flag | output | 1 | ALU result is zero |
| in_rd | output | 1 | Read strobe to the addressed input port |
| out_wr | output | 1 | One-cycle output write strobe |
| out_data | output | 16 | Output word |
| out_addr | output | 8 | Output port address |

## Verification
The assertions assume the sequencer never raises `in_en` and `out_en` in the same cycle. They also assume the control inputs are known whenever reset is released. The stimulus drives every control field at the falling edge and keeps both inputs valid at all times. Its random phase draws one port action per cycle at most, chosen from input, output or neither. Function code 15 is exercised only in directed steps.

// File: rtl/pu_pkg.sv
package pu_pkg;
  typedef enum logic [3:0] {
    FN_AND   = 4'd0,
    FN_OR    = 4'd1,
    FN_XOR   = 4'd2,
    FN_NOT   = 4'd3,
    FN_ADD   = 4'd4,
    FN_SUB   = 4'd5,
    FN_SHA   = 4'd6,
    FN_SHL   = 4'd7,
    FN_LT    = 4'd8,
    FN_LE    = 4'd9,
    FN_EQ    = 4'd10,
    FN_LTU   = 4'd11,
    FN_LEU   = 4'd12,
    FN_MOV   = 4'd13,
    FN_MOVHI = 4'd14,
    FN_RSVD  = 4'd15
  } alu_fn_e;
endpackage

// File: rtl/pu_regbank.sv
module pu_regbank #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] sel_a,
  input  logic [$clog2(NREG)-1:0] sel_b,
  input  logic [$clog2(NREG)-1:0] sel_w,
  input  logic                    we,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rd_a,
  output logic [DATA_W-1:0]       rd_b
);
  logic [DATA_W-1:0] regs [NREG];
  logic [NREG-1:0]   hit;

  // one decoded write enable per register
  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = we && (sel_w == g[$clog2(NREG)-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (hit[i]) regs[i] <= wdata;
    end
  end

  assign rd_a = regs[sel_a];
  assign rd_b = regs[sel_b];
endmodule

// File: rtl/pu_shifter.sv
module pu_shifter #(
  parameter int DATA_W = 16,
  parameter int SH_W   = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] sha_res,
  output logic [DATA_W-1:0] shl_res
);
  logic              neg;
  logic [SH_W-1:0]   mag;
  logic [DATA_W-1:0] left_v;
  logic [DATA_W-1:0] right_l;
  logic [DATA_W-1:0] right_a;

  assign neg     = amt[SH_W-1];
  assign mag     = neg ? ((~amt) + SH_W'(1)) : amt;
  assign left_v  = a << mag;
  assign right_l = a >> mag;
  assign right_a = $signed(a) >>> mag;

  assign sha_res = neg ? right_a : left_v;
  assign shl_res = neg ? right_l : left_v;
endmodule

// File: rtl/pu_alu.sv
module pu_alu
  import pu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        fn,
  output logic [DATA_W-1:0] res,
  output logic              zero
);
  localparam int SH_W = $clog2(DATA_W) + 1;
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] sha_v, shl_v;
  logic              lt_s, lt_u, eq_v;
  alu_fn_e           op;

  assign op = alu_fn_e'(fn);

  pu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .a       (a),
    .amt     (b[SH_W-1:0]),
    .sha_res (sha_v),
    .shl_res (shl_v)
  );

  assign lt_s = $signed(a) < $signed(b);
  assign lt_u = a < b;
  assign eq_v = a == b;

  always_comb begin
    res = '0;
    unique case (op)
      FN_AND:   res = a & b;
      FN_OR:    res = a | b;
      FN_XOR:   res = a ^ b;
      FN_NOT:   res = ~a;
      FN_ADD:   res = a + b;
      FN_SUB:   res = a - b;
      FN_SHA:   res = sha_v;
      FN_SHL:   res = shl_v;
      FN_LT:    res = DATA_W'(lt_s);
      FN_LE:    res = DATA_W'(lt_s | eq_v);
      FN_EQ:    res = DATA_W'(eq_v);
      FN_LTU:   res = DATA_W'(lt_u);
      FN_LEU:   res = DATA_W'(lt_u | eq_v);
      FN_MOV:   res = b;
      FN_MOVHI: res = {b[HALF-1:0], a[HALF-1:0]};
      FN_RSVD:  res = '0;
    endcase
  end

  assign zero = ~|res;
endmodule

// File: rtl/pu_outport.sv
module pu_outport #(
  parameter int DATA_W = 16,
  parameter int IOA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] data_i,
  input  logic [IOA_W-1:0]  addr_i,
  output logic              wr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [IOA_W-1:0]  addr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_o   <= 1'b0;
      data_o <= '0;
      addr_o <= '0;
    end else begin
      wr_o <= fire;
      if (fire) begin
        data_o <= data_i;
        addr_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/pu_datapath.sv
module pu_datapath #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  parameter int IOA_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] sel_a,
  input  logic [$clog2(NREG)-1:0] sel_b,
  input  logic [$clog2(NREG)-1:0] sel_d,
  input  logic                    use_imm,
  input  logic [DATA_W-1:0]       imm,
  input  logic [3:0]              alu_fn,
  input  logic                    wr_en,
  input  logic                    in_en,
  input  logic                    out_en,
  input  logic [IOA_W-1:0]        io_addr,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    zero_flag,
  output logic                    in_rd,
  output logic                    out_wr,
  output logic [DATA_W-1:0]       out_data,
  output logic [IOA_W-1:0]        out_addr
);
  logic [DATA_W-1:0] a_bus, rb_bus, b_bus, alu_res, wr_data;
  logic              wr_go;

  assign b_bus   = use_imm ? imm : rb_bus;
  assign in_rd   = in_en & ~out_en;
  assign wr_data = in_rd ? in_data : alu_res;
  assign wr_go   = wr_en & ~out_en;

  pu_regbank #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .sel_w (sel_d),
    .we    (wr_go),
    .wdata (wr_data),
    .rd_a  (a_bus),
    .rd_b  (rb_bus)
  );

  pu_alu #(.DATA_W(DATA_W)) u_alu (
    .a    (a_bus),
    .b    (b_bus),
    .fn   (alu_fn),
    .res  (alu_res),
    .zero (zero_flag)
  );

  pu_outport #(.DATA_W(DATA_W), .IOA_W(IOA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (out_en),
    .data_i (a_bus),
    .addr_i (io_addr),
    .wr_o   (out_wr),
    .data_o (out_data),
    .addr_o (out_addr)
  );
endmodule

// File: rtl/pu_datapath_chk.sv
module pu_datapath_chk
  import pu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IOA_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_en,
  input logic              out_en,
  input logic              in_rd,
  input logic              out_wr,
  input logic [DATA_W-1:0] out_data,
  input logic [IOA_W-1:0]  out_addr,
  input logic [IOA_W-1:0]  io_addr,
  input logic [3:0]        alu_fn,
  input logic [DATA_W-1:0] a_bus,
  input logic [DATA_W-1:0] b_bus,
  input logic [DATA_W-1:0] alu_res,
  input logic              zero_flag
);
  localparam int HALF = DATA_W / 2;

  // R12
  out_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> out_wr);

  // R12
  out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr |-> ($past(out_en) && out_data == $past(a_bus) && out_addr == $past(io_addr)));

  // R6
  cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn >= 4'(FN_LT) && alu_fn <= 4'(FN_LEU)) |-> (alu_res[DATA_W-1:1] == '0));

  // R10
  eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == 4'(FN_EQ)) |-> (zero_flag == (a_bus != b_bus)));

  // R8
  movhi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == 4'(FN_MOVHI)) |->
      (alu_res[HALF-1:0] == a_bus[HALF-1:0] && alu_res[DATA_W-1:HALF] == b_bus[HALF-1:0]));

  // R11
  in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rd |-> (in_en && !out_en));
endmodule

bind pu_datapath pu_datapath_chk #(.DATA_W(DATA_W), .IOA_W(IOA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_en     (in_en),
  .out_en    (out_en),
  .in_rd     (in_rd),
  .out_wr    (out_wr),
  .out_data  (out_data),
  .out_addr  (out_addr),
  .io_addr   (io_addr),
  .alu_fn    (alu_fn),
  .a_bus     (a_bus),
  .b_bus     (b_bus),
  .alu_res   (alu_res),
  .zero_flag (zero_flag)
);

// File: tb/pu_datapath_tb.sv
module pu_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel_a = '0, sel_b = '0, sel_d = '0;
  logic        use_imm = 1'b0;
  logic [15:0] imm = '0;
  logic [3:0]  alu_fn = '0;
  logic        wr_en = 1'b0, in_en = 1'b0, out_en = 1'b0;
  logic [7:0]  io_addr = '0;
  logic [15:0] in_data = '0;
  logic        zero_flag, in_rd, out_wr;
  logic [15:0] out_data;
  logic [7:0]  out_addr;

  int n_run  = 0;
  int n_fail = 0;
  logic [15:0] mregs [8];

  always #4 clk = ~clk;

  pu_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b), .sel_d(sel_d),
    .use_imm(use_imm), .imm(imm), .alu_fn(alu_fn), .wr_en(wr_en),
    .in_en(in_en), .out_en(out_en), .io_addr(io_addr), .in_data(in_data),
    .zero_flag(zero_flag), .in_rd(in_rd), .out_wr(out_wr),
    .out_data(out_data), .out_addr(out_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_alu(input int fn, input logic [15:0] a, input logic [15:0] b);
    int amt, n, sa;
    case (fn)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      3: return ~a;
      4: return a + b;
      5: return a - b;
      6, 7: begin
        amt = int'(b[4:0]);
        if (amt >= 16) amt -= 32;
        if (amt >= 0) return 16'(a << amt);
        n = -amt;
        if (fn == 7) return 16'(a >> n);
        sa = int'($signed(a));
        return 16'(sa >>> n);
      end
      8:  return ($signed(a) <  $signed(b)) ? 16'd1 : 16'd0;
      9:  return ($signed(a) <= $signed(b)) ? 16'd1 : 16'd0;
      10: return (a == b) ? 16'd1 : 16'd0;
      11: return (a <  b) ? 16'd1 : 16'd0;
      12: return (a <= b) ? 16'd1 : 16'd0;
      13: return b;
      14: return {b[7:0], a[7:0]};
      default: return 16'd0;
    endcase
  endfunction

  // one control word per cycle, compared against the model
  task automatic op(input string tag, input int fn, input int sa, input int sb, input int sd,
                    input logic ui, input logic [15:0] iv, input logic we,
                    input logic ie, input logic oe, input logic [7:0] ad, input logic [15:0] din);
    logic [15:0] bv, r, av;
    @(negedge clk);
    sel_a = 3'(sa); sel_b = 3'(sb); sel_d = 3'(sd); use_imm = ui; imm = iv;
    alu_fn = 4'(fn); wr_en = we; in_en = ie; out_en = oe; io_addr = ad; in_data = din;
    av = mregs[sa];
    bv = ui ? iv : mregs[sb];
    r  = ref_alu(fn, av, bv);
    #2;
    chk({tag, "/R10 zero"}, 32'(zero_flag), 32'(r == 16'd0));
    chk("R11 in_rd", 32'(in_rd), 32'(ie && !oe));
    @(posedge clk);
    #2;
    chk("R12 out_wr", 32'(out_wr), 32'(oe));
    if (oe) begin
      chk({tag, "/R12 data"}, 32'(out_data), 32'(av));
      chk("R12 addr", 32'(out_addr), 32'(ad));
    end
    if (we && !oe) mregs[sd] = (ie ? din : r);
  endtask

  task automatic show(input string tag, input int r);
    op(tag, 13, r, 0, 0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1, 8'(8'h40 + r), 16'h0);
  endtask

  task automatic calc(input string tag, input int fn, input int sa, input int sb,
                      input logic ui, input logic [15:0] iv);
    op(tag, fn, sa, sb, 5, ui, iv, 1'b1, 1'b0, 1'b0, 8'h0, 16'h0);
    show(tag, 5);
  endtask

  task automatic load(input int r, input logic [15:0] v);
    op("R11", 0, 0, 0, r, 1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 8'(r), v);
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mregs[i] = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 out_wr at reset", 32'(out_wr), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) show("R1", i);

    load(1, 16'h1234); load(2, 16'h00F0); load(3, 16'h8001); load(4, 16'hFFFF);
    load(6, 16'h7FFF); load(7, 16'h0003);
    for (int i = 1; i < 8; i++) show("R2", i);

    calc("R3", 0, 1, 2, 1'b0, 0);  calc("R3", 1, 1, 2, 1'b0, 0);
    calc("R3", 2, 1, 4, 1'b0, 0);  calc("R3", 3, 3, 0, 1'b0, 0);
    calc("R4", 4, 4, 7, 1'b0, 0);  calc("R4", 5, 0, 7, 1'b0, 0);
    calc("R4", 4, 6, 6, 1'b0, 0);
    calc("R5", 6, 3, 0, 1'b1, 16'h0001);  calc("R5", 6, 3, 0, 1'b1, 16'h001F);
    calc("R5", 7, 3, 0, 1'b1, 16'h001F);  calc("R5", 6, 3, 0, 1'b1, 16'h0010);
    calc("R5", 7, 3, 0, 1'b1, 16'h0010);  calc("R5", 7, 1, 0, 1'b1, 16'h000F);
    calc("R6", 8, 3, 1, 1'b0, 0);  calc("R6", 8, 1, 3, 1'b0, 0);
    calc("R6", 9, 4, 4, 1'b0, 0);  calc("R6", 10, 1, 2, 1'b0, 0);
    calc("R6", 10, 2, 2, 1'b0, 0);
    calc("R7", 11, 3, 1, 1'b0, 0); calc("R7", 11, 1, 3, 1'b0, 0);
    calc("R7", 12, 4, 4, 1'b0, 0); calc("R7", 12, 4, 1, 1'b0, 0);
    calc("R8", 13, 0, 0, 1'b1, 16'hBEEF);
    calc("R8", 14, 5, 0, 1'b1, 16'h00A5);
    calc("R8", 15, 4, 4, 1'b0, 0);
    calc("R9", 4, 1, 4, 1'b1, 16'h0001);
    calc("R9", 4, 1, 4, 1'b0, 16'h0001);
    // write then read the same register in the next cycle
    op("R2", 4, 1, 1, 2, 1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 0);
    show("R2", 2);
    // output with wr_en set must not write
    op("R12", 13, 6, 0, 6, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b1, 8'h77, 0);
    show("R12", 6);
    // wr_en low keeps registers
    op("R13", 13, 0, 0, 7, 1'b1, 16'hAAAA, 1'b0, 1'b0, 1'b0, 0, 0);
    show("R13", 7);

    for (int k = 0; k < 600; k++) begin
      int sel;
      sel = $urandom_range(0, 3);
      op("rand", $urandom_range(0, 14), $urandom_range(0, 7), $urandom_range(0, 7),
         $urandom_range(0, 7), 1'($urandom_range(0, 1)), 16'($urandom),
         1'($urandom_range(0, 1)), sel == 1, sel == 2, 8'($urandom), 16'($urandom));
    end
    for (int i = 0; i < 8; i++) show("R2", i);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule